// File: doc/BRIEF.md
# Pointer/Data Indirect Register Port

This block is a bus master on the host side of a device whose large per-channel register space can only be reached through two 32-bit port registers: a pointer register and a data register. A requester issues one command that names a register identifier, a channel number and (for writes) a data word. The block first writes a pointer word that combines the register address and the channel. It then reads or writes the data register, and it reports completion with a one-cycle done pulse.

The upper byte of the register identifier can describe a bitfield inside the 32-bit register, giving its width and its starting bit. A field read returns the field right-justified. A field write becomes a read-modify-write: the block reads the data register, keeps every bit outside the field and writes the merged word back. The port carries no other traffic while this runs. The register address mask applied to the pointer word is chosen per command by a variant input, because two device generations decode different address widths.

A busy flag covers the whole sequence. While it is high the block takes no new command, so each command holds the two port registers until it finishes.

Top module: `irp_port`

## Requirements
- R1: The pointer word equals ((id << 16) & M) | (chan & ((1 << CHAN_W) - 1)), where id is the register identifier, chan is the channel number and M is ADDR_MASK_A when variant_sel is 0 and ADDR_MASK_B when it is 1. Port select value 0 addresses the pointer register.
- R2: A command is a field access exactly when identifier bits 31:24 are not all zero. The field width is taken from identifier bits 29:24 and the field start bit from bits 20:16.
- R3: A plain read returns the whole 32-bit data register word on rsp_rdata in the cycle that done is high. Port select value 1 addresses the data register.
- R4: A field read returns (word & F) >> start, where F = ((1 << width) - 1) << start, truncated to 32 bits.
- R5: A field width of 32 or more uses a full 32-bit mask F, so a field read returns word >> start and a field write replaces the whole word with wdata << start.
- R6: A plain write performs one pointer write and then exactly one data write of cmd_wdata, with no data read.
- R7: A field write performs one pointer write, one data read, and one data write of (old & ~F) | ((wdata << start) & F).
- R8: After the accepting clock edge, each cycle carries one port access in a fixed order: the pointer write, then the data access. The single-cycle done pulse follows 3 cycles after acceptance for a plain write, 4 cycles for a read and 5 cycles for a field write.
- R9: busy is high from the cycle after acceptance through the done cycle. A command presented while busy is high is dropped and causes no port access.
- R10: port_wen and port_ren are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken only when busy is low |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_reg | input | 32 | Register identifier, with the field width and start in its upper byte |
| cmd_chan | input | CHAN_IN_W | Channel number |
| cmd_wdata | input | 32 | Write data (the field value for field writes) |
| variant_sel | input | 1 | Address mask choice: 0 = ADDR_MASK_A, 1 = ADDR_MASK_B |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, valid while done is high after a read |
| port_sel | output | 1 | 0 = pointer register, 1 = data register |
| port_wen | output | 1 | Port write strobe |
| port_ren | output | 1 | Port read strobe |
| port_wdata | output | 32 | Port write data |
| port_rdata | input | 32 | Port read data, valid in the cycle after port_ren |

## Verification
The assertions assume that the port slave returns read data in the cycle after a read strobe and holds it there. They also assume that command fields stay settled while cmd_valid is high at an accepting edge. The bench models the slave as a registered read path over a small memory indexed by pointer bits 19:16 and channel bits 1:0. It changes command inputs only on falling edges, so every accepted command sees settled inputs. Commands aimed at the block while it is busy are presented on purpose, and the checks confirm they are dropped.

// File: rtl/irp_pkg.sv
package irp_pkg;

    localparam int WORD_W   = 32;
    localparam int WIDTH_LSB = 24;
    localparam int WIDTH_W   = 6;
    localparam int START_LSB = 16;
    localparam int START_W   = 5;
    localparam int ADDR_SHIFT = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_DRD,
        ST_DCAP,
        ST_DWR,
        ST_DONE
    } seq_state_e;

    typedef enum logic {
        SEL_PTR  = 1'b0,
        SEL_DATA = 1'b1
    } port_sel_e;

    typedef struct packed {
        logic                is_write;
        logic                is_field;
        logic [START_W-1:0]  start;
        word_t               field_mask;
        word_t               ptr_word;
        word_t               wdata;
    } cmd_s;

    // Mask for a field of the given width placed at the given start bit.
    // Widths of a full word or more give an all-ones mask.
    function automatic word_t field_mask_f(input logic [WIDTH_W-1:0] width,
                                           input logic [START_W-1:0] start);
        word_t low;
        if (width >= WIDTH_W'(WORD_W)) begin
            return '1;
        end
        low = (word_t'(1) << width) - word_t'(1);
        return low << start;
    endfunction

endpackage

// File: rtl/irp_decode.sv
module irp_decode
    import irp_pkg::*;
#(
    parameter word_t ADDR_MASK_A = 32'h001F_0000,
    parameter word_t ADDR_MASK_B = 32'h0FFF_0000,
    parameter int    CHAN_IN_W   = 8,
    parameter int    CHAN_W      = 6
) (
    input  logic                 is_write,
    input  word_t                reg_id,
    input  logic [CHAN_IN_W-1:0] chan,
    input  word_t                wdata,
    input  logic                 variant,
    output cmd_s                 cmd
);

    localparam word_t CHAN_MASK = (word_t'(1) << CHAN_W) - word_t'(1);

    word_t               addr_mask;
    logic [WIDTH_W-1:0]  f_width;
    logic [START_W-1:0]  f_start;

    always_comb begin
        addr_mask = variant ? ADDR_MASK_B : ADDR_MASK_A;
        f_width   = reg_id[WIDTH_LSB +: WIDTH_W];
        f_start   = reg_id[START_LSB +: START_W];

        cmd.is_write   = is_write;
        cmd.is_field   = |reg_id[WORD_W-1:WIDTH_LSB];
        cmd.start      = f_start;
        cmd.field_mask = field_mask_f(f_width, f_start);
        cmd.ptr_word   = ((reg_id << ADDR_SHIFT) & addr_mask)
                       | (word_t'(chan) & CHAN_MASK);
        cmd.wdata      = wdata;
    end

endmodule

// File: rtl/irp_merge.sv
module irp_merge
    import irp_pkg::*;
(
    input  word_t               rd_word,
    input  word_t               field_mask,
    input  logic [START_W-1:0]  start,
    input  word_t               wdata,
    output word_t               extract,
    output word_t               merged
);

    always_comb begin
        extract = (rd_word & field_mask) >> start;
        merged  = (rd_word & ~field_mask) | ((wdata << start) & field_mask);
    end

endmodule

// File: rtl/irp_seq.sv
module irp_seq
    import irp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       is_write,
    input  logic       is_field,
    output seq_state_e state,
    output logic       busy,
    output logic       done
);

    seq_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_PTR;
            ST_PTR:  state_nx = (is_write && !is_field) ? ST_DWR : ST_DRD;
            ST_DRD:  state_nx = ST_DCAP;
            ST_DCAP: state_nx = is_write ? ST_DWR : ST_DONE;
            ST_DWR:  state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/irp_port.sv
module irp_port
    import irp_pkg::*;
#(
    parameter logic [31:0] ADDR_MASK_A = 32'h001F_0000,
    parameter logic [31:0] ADDR_MASK_B = 32'h0FFF_0000,
    parameter int          CHAN_IN_W   = 8,
    parameter int          CHAN_W      = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic                 cmd_write,
    input  logic [31:0]          cmd_reg,
    input  logic [CHAN_IN_W-1:0] cmd_chan,
    input  logic [31:0]          cmd_wdata,
    input  logic                 variant_sel,
    output logic                 busy,
    output logic                 done,
    output logic [31:0]          rsp_rdata,
    output logic                 port_sel,
    output logic                 port_wen,
    output logic                 port_ren,
    output logic [31:0]          port_wdata,
    input  logic [31:0]          port_rdata
);

    localparam word_t CHAN_MASK = (word_t'(1) << CHAN_W) - word_t'(1);

    cmd_s       dec_cmd;
    cmd_s       cmd_q;
    word_t      data_q;
    word_t      ext_word;
    word_t      mrg_word;
    seq_state_e state;
    logic       accept;

    irp_decode #(
        .ADDR_MASK_A (ADDR_MASK_A),
        .ADDR_MASK_B (ADDR_MASK_B),
        .CHAN_IN_W   (CHAN_IN_W),
        .CHAN_W      (CHAN_W)
    ) u_decode (
        .is_write (cmd_write),
        .reg_id   (cmd_reg),
        .chan     (cmd_chan),
        .wdata    (cmd_wdata),
        .variant  (variant_sel),
        .cmd      (dec_cmd)
    );

    irp_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .is_write (cmd_q.is_write),
        .is_field (cmd_q.is_field),
        .state    (state),
        .busy     (busy),
        .done     (done)
    );

    irp_merge u_merge (
        .rd_word    (port_rdata),
        .field_mask (cmd_q.field_mask),
        .start      (cmd_q.start),
        .wdata      (cmd_q.wdata),
        .extract    (ext_word),
        .merged     (mrg_word)
    );

    assign accept = cmd_valid && (state == ST_IDLE);

    // Command register: loaded only from idle, so a busy sequence keeps its command.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= dec_cmd;
        end
    end

    // Data capture: read result or merged write-back word.
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (state == ST_DCAP) begin
            if (cmd_q.is_write)      data_q <= mrg_word;
            else if (cmd_q.is_field) data_q <= ext_word;
            else                     data_q <= port_rdata;
        end
    end

    assign rsp_rdata = data_q;

    // Port drive: one access per sequence step.
    always_comb begin
        port_sel   = SEL_PTR;
        port_wen   = 1'b0;
        port_ren   = 1'b0;
        port_wdata = '0;
        unique case (state)
            ST_PTR: begin
                port_sel   = SEL_PTR;
                port_wen   = 1'b1;
                port_wdata = cmd_q.ptr_word;
            end
            ST_DRD: begin
                port_sel = SEL_DATA;
                port_ren = 1'b1;
            end
            ST_DWR: begin
                port_sel   = SEL_DATA;
                port_wen   = 1'b1;
                port_wdata = cmd_q.is_field ? data_q : cmd_q.wdata;
            end
            default: begin
                port_sel = SEL_PTR;
            end
        endcase
    end

    p_port_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(port_wen && port_ren));

    p_ptr_first_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (port_wen && port_sel == SEL_PTR));

    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_q));

    p_ptr_bits_r1: assert property (@(posedge clk) disable iff (rst)
        (port_wen && port_sel == SEL_PTR) |->
        ((port_wdata & ~(ADDR_MASK_A | ADDR_MASK_B | CHAN_MASK)) == '0));

    p_merge_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DCAP && cmd_q.is_field) |->
        (((mrg_word ^ port_rdata) & ~cmd_q.field_mask) == '0));

    p_extract_fit_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DCAP && cmd_q.is_field) |->
        ((ext_word & ~(cmd_q.field_mask >> cmd_q.start)) == '0));

    p_data_after_ptr_r8: assert property (@(posedge clk) disable iff (rst)
        (port_wen && port_sel == SEL_PTR) |=> ((port_wen || port_ren) && port_sel == SEL_DATA));

endmodule

// File: tb/sim_irp_port.sv
module sim_irp_port;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MASK_A = 32'h001F_0000;
    localparam logic [31:0] MASK_B = 32'h0FFF_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, cmd_write, variant_sel;
    logic [31:0] cmd_reg, cmd_wdata;
    logic [7:0]  cmd_chan;
    logic        busy, done, port_sel, port_wen, port_ren;
    logic [31:0] rsp_rdata, port_wdata, port_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Port slave model
    logic [31:0] mem [64];
    logic [31:0] ptr_reg;
    logic [31:0] rd_q;
    int n_pw, n_dw, n_dr;
    bit overlap_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irp_port #(.ADDR_MASK_A(MASK_A), .ADDR_MASK_B(MASK_B), .CHAN_IN_W(8), .CHAN_W(6)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_reg(cmd_reg), .cmd_chan(cmd_chan), .cmd_wdata(cmd_wdata),
        .variant_sel(variant_sel), .busy(busy), .done(done), .rsp_rdata(rsp_rdata),
        .port_sel(port_sel), .port_wen(port_wen), .port_ren(port_ren),
        .port_wdata(port_wdata), .port_rdata(port_rdata)
    );

    function automatic int slot(input logic [31:0] p);
        return int'({p[19:16], p[1:0]});
    endfunction

    always @(posedge clk) begin
        if (port_wen && port_ren) overlap_seen = 1;
        if (port_wen && !port_sel) begin ptr_reg <= port_wdata; n_pw++; end
        if (port_wen && port_sel)  begin mem[slot(ptr_reg)] <= port_wdata; n_dw++; end
        if (port_ren && port_sel)  begin rd_q <= mem[slot(ptr_reg)]; n_dr++; end
    end
    assign port_rdata = rd_q;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_mask(input int width, input int start);
        logic [63:0] m;
        if (width >= 32) return 32'hFFFF_FFFF;
        m = ((64'd1 << width) - 64'd1) << start;
        return m[31:0];
    endfunction

    function automatic logic [31:0] field_id(input int width, input int start, input int regn);
        return {2'b00, 6'(width), 3'b000, 5'(start), 12'h000, 4'(regn)};
    endfunction

    task automatic run_cmd(input bit wr, input logic [31:0] id, input logic [7:0] ch,
                           input logic [31:0] wd, input bit var_sel,
                           output logic [31:0] rdat, output int cyc);
        while (busy) @(negedge clk);
        n_pw = 0; n_dw = 0; n_dr = 0;
        cmd_valid = 1; cmd_write = wr; cmd_reg = id; cmd_chan = ch;
        cmd_wdata = wd; variant_sel = var_sel;
        cyc = 0;
        @(negedge clk);
        cmd_valid = 0;
        cyc = 1;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        rdat = rsp_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, expw, m, base, wdv;
        int cyc;
        rst = 1; cmd_valid = 0; cmd_write = 0; cmd_reg = 0; cmd_chan = 0;
        cmd_wdata = 0; variant_sel = 0; ptr_reg = 0; rd_q = 0;
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // Reset state
        check(!busy && !done && !port_wen && !port_ren, "R9 reset idle",
              {28'h0, busy, done, port_wen, port_ren}, 32'h0);

        // R1: pointer word for both address masks, channel masking
        for (int v = 0; v < 2; v++) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] id;
                logic [7:0] ch;
                id = 32'h0000_0ABC + 32'(k * 32'h0101);
                ch = 8'(8'hC5 + k * 17);
                run_cmd(1, id, ch, 32'h1234_0000 + 32'(k), v[0], rd, cyc);
                expw = ((id << 16) & (v ? MASK_B : MASK_A)) | (32'(ch) & 32'h3F);
                check(ptr_reg == expw, "R1 pointer word", ptr_reg, expw);
            end
        end

        // R3 / R6 / R8: plain write then plain read over a sweep of registers and channels
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                wdv = 32'h9E37_79B9 * 32'(r * 4 + c + 1);
                run_cmd(1, 32'(r), 8'(c), wdv, 0, rd, cyc);
                check(cyc == 3, "R8 plain write latency", 32'(cyc), 32'd3);
                check(n_pw == 1 && n_dw == 1 && n_dr == 0, "R6 plain write accesses",
                      32'(n_pw * 256 + n_dw * 16 + n_dr), 32'h110);
                @(negedge clk);
                check(!done, "R8 done single cycle", {31'h0, done}, 32'h0);
                run_cmd(0, 32'(r), 8'(c), 32'h0, 0, rd, cyc);
                check(cyc == 4, "R8 read latency", 32'(cyc), 32'd4);
                check(rd == wdv, "R3 plain read word", rd, wdv);
            end
        end

        // R2 / R4 / R5: field read sweep over all widths and start bits
        base = 32'hA5C3_9E17;
        run_cmd(1, 32'd5, 8'd2, base, 0, rd, cyc);
        for (int w = 0; w < 64; w++) begin
            for (int s = 0; s < 32; s++) begin
                run_cmd(0, field_id(w, s, 5), 8'd2, 32'h0, 0, rd, cyc);
                if (w == 0) begin
                    // upper byte zero: plain read of the whole word
                    check(rd == base, "R2 zero upper byte is plain", rd, base);
                end else begin
                    m = exp_mask(w, s);
                    expw = (base & m) >> s;
                    if (w >= 32) check(rd == expw, "R5 saturated field read", rd, expw);
                    else         check(rd == expw, "R4 field read", rd, expw);
                end
            end
        end

        // R7 / R5: field write, then plain read back
        for (int w = 1; w < 36; w += 2) begin
            for (int s = 0; s < 32; s += 3) begin
                base = 32'h3C5A_F00F ^ 32'(w * 977 + s);
                wdv  = 32'hDEAD_BEEF ^ 32'(s * 131);
                run_cmd(1, 32'd9, 8'd1, base, 0, rd, cyc);
                run_cmd(1, field_id(w, s, 9), 8'd1, wdv, 0, rd, cyc);
                check(cyc == 5, "R8 field write latency", 32'(cyc), 32'd5);
                check(n_pw == 1 && n_dr == 1 && n_dw == 1, "R7 field write accesses",
                      32'(n_pw * 256 + n_dw * 16 + n_dr), 32'h111);
                m = exp_mask(w, s);
                expw = (base & ~m) | ((wdv << s) & m);
                run_cmd(0, 32'd9, 8'd1, 32'h0, 0, rd, cyc);
                if (w >= 32) check(rd == expw, "R5 saturated field write", rd, expw);
                else         check(rd == expw, "R7 field merge", rd, expw);
            end
        end

        // R9: commands during busy are dropped
        run_cmd(1, 32'd2, 8'd2, 32'h5555_AAAA, 0, rd, cyc);
        run_cmd(1, 32'd1, 8'd1, 32'h0000_0000, 0, rd, cyc);
        while (busy) @(negedge clk);
        n_pw = 0; n_dw = 0; n_dr = 0;
        cmd_valid = 1; cmd_write = 1; cmd_reg = 32'd1; cmd_chan = 8'd1;
        cmd_wdata = 32'h1111_2222; variant_sel = 0;
        @(negedge clk);
        check(busy, "R9 busy after accept", {31'h0, busy}, 32'h1);
        cmd_reg = 32'd2; cmd_chan = 8'd2; cmd_wdata = 32'hFFFF_0000;
        while (!done) @(negedge clk);
        check(n_pw == 1 && n_dw == 1, "R9 no extra access while busy",
              32'(n_pw * 16 + n_dw), 32'h11);
        cmd_valid = 0;
        @(negedge clk);
        run_cmd(0, 32'd2, 8'd2, 32'h0, 0, rd, cyc);
        check(rd == 32'h5555_AAAA, "R9 busy command dropped", rd, 32'h5555_AAAA);
        run_cmd(0, 32'd1, 8'd1, 32'h0, 0, rd, cyc);
        check(rd == 32'h1111_2222, "R9 accepted command kept", rd, 32'h1111_2222);

        check(!overlap_seen, "R10 no read and write together", {31'h0, overlap_seen}, 32'h0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule